// File: doc/BRIEF.md
# Quadrature Sample Interval Reconstructor

This block turns two pairs of digitized quadrature amplitudes into one time interval. A pair is taken at the start event and another at the stop event. A count of whole oscillator periods between the two events comes with them. The block removes a programmable midscale offset from each unsigned converter code, which gives signed x and y. It then finds the phase angle of each pair with an iterative full-circle arctangent. A loaded table of nonuniform angle edges turns that angle into a time bin. Each bin stands for an equal slice of one period, so one output LSB is the period divided by the bin count. The length of the vector carries no time information and does not affect the result.

The interval is the coarse count times the bins per period, plus the stop bin, minus the start bin. It is produced as a signed number. One event pair is processed at a time, and both pairs go through a single arctangent engine and a single bin search. Input is accepted through a valid/ready handshake. The result is held on a valid/ready output until it is taken. The edge table is loaded through a simple write port whenever no conversion is running.

Top module: `dual_phase_interval`

## Requirements
- R1: After reset, `inReady` is high and `outValid` is low.
- R2: A pair is accepted on a rising edge where `inValid` and `inReady` are both high. `inReady` goes low on that edge and stays low until the result has been taken. Input values presented while `inReady` is low have no effect on the result.
- R3: `outValid` rises exactly 2·(ITER+clog2(NBINS)+3)+1 rising edges after the accepting edge. It stays high, with `intervalLsb` unchanged, until a rising edge with `outReady` high. On that edge `inReady` returns high.
- R4: Each signed amplitude is the input code minus `midCode`, where `midCode` is the value captured on the accepting edge.
- R5: The phase of a pair is the four-quadrant arctangent of y over x, as an ANGLE_W-bit unsigned code for a full turn. Code 0 lies on the positive x axis, which is the edge on which the coarse counter advances. The code grows toward the positive y axis. Scaling both amplitudes by the same factor leaves the bin unchanged.
- R6: The table holds NBINS−1 ascending edge codes at addresses 0 to NBINS−2. A phase's bin is the number of edges less than or equal to its code, from 0 to NBINS−1.
- R7: `intervalLsb` = coarse·NBINS + stopBin − startBin, in two's complement. It is negative when the stop bin is lower than the start bin and the coarse count is zero.
- R8: A write with `tabWrEn` high stores `tabData` at `tabAddr` on the rising edge. Pairs accepted after that edge use the new edge. Addresses of NBINS−1 and above are ignored.
- R9: The full coarse range up to 2^CNT_W−1 gives the exact result without overflow.
- R10: A vector just below the positive x axis lands in the last bin, not in bin 0. This applies to the fourth quadrant, where the phase is close to a full turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Event pair and coarse count are present |
| inReady | output | 1 | Block can accept a pair |
| startX | input | ADC_W | Start event, x amplitude code |
| startY | input | ADC_W | Start event, y amplitude code |
| stopX | input | ADC_W | Stop event, x amplitude code |
| stopY | input | ADC_W | Stop event, y amplitude code |
| coarseCnt | input | CNT_W | Whole periods between the events |
| midCode | input | ADC_W | Midscale offset removed from every code |
| tabWrEn | input | 1 | Edge table write strobe |
| tabAddr | input | clog2(NBINS) | Edge table write address |
| tabData | input | ANGLE_W | Edge angle code to store |
| outValid | output | 1 | Result is present |
| outReady | input | 1 | Consumer takes the result |
| intervalLsb | output | CNT_W+clog2(NBINS)+2 | Signed interval in time LSBs |

## Verification
The bench builds the block with NBINS=8, ITER=16, ADC_W=12, ANGLE_W=16 and CNT_W=9. Eight bins keep the edge table to seven writes and make the latency 45 edges. With so few bins, every bin can be reached, including the last bin that wraps past the positive x axis. The test vectors can sit several hundred angle codes away from any edge, so the small arctangent error can never move a vector into another bin. The coarse count of 511 exercises the widest sum that the chosen result width must hold.

// File: rtl/dptr_pkg.sv
`timescale 1ns/1ps
package dptr_pkg;

  // strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch the incoming pair set
    logic cordLoad;  // pre-rotate the selected pair
    logic cordStep;  // one micro-rotation
    logic srchLoad;  // latch angle, clear candidate
    logic srchStep;  // resolve one candidate bit
    logic saveBin;   // store candidate as bin of selected pair
    logic calcOut;   // assemble the signed interval
    logic pairSel;   // 0 = start pair, 1 = stop pair
  } ctrlStrobes_t;

  // arctan(2^-i) as a fraction of a full turn, scaled by 2^32
  function automatic logic [31:0] atanTurn32(input int idx);
    case (idx)
      0:  return 32'h20000000;
      1:  return 32'h12E4051E;
      2:  return 32'h09FB385B;
      3:  return 32'h051111D4;
      4:  return 32'h028B0D43;
      5:  return 32'h0145D7E1;
      6:  return 32'h00A2F61E;
      7:  return 32'h00517C55;
      8:  return 32'h0028BE53;
      9:  return 32'h00145F2F;
      10: return 32'h000A2F98;
      11: return 32'h000517CC;
      12: return 32'h00028BE6;
      13: return 32'h000145F3;
      14: return 32'h0000A2FA;
      15: return 32'h0000517D;
      16: return 32'h000028BE;
      17: return 32'h0000145F;
      18: return 32'h00000A30;
      19: return 32'h00000518;
      20: return 32'h0000028C;
      21: return 32'h00000146;
      22: return 32'h000000A3;
      23: return 32'h00000051;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/dptr_cordic.sv
`timescale 1ns/1ps
module dptr_cordic
  import dptr_pkg::*;
#(
  parameter int ADC_W   = 12,
  parameter int ANGLE_W = 16,
  parameter int ITER    = 16,
  parameter int SEQ_W   = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   load,
  input  logic                   step,
  input  logic [SEQ_W-1:0]       stepIdx,
  input  logic signed [ADC_W:0]  xIn,
  input  logic signed [ADC_W:0]  yIn,
  output logic [ANGLE_W-1:0]     angle
);

  localparam int GUARD = 4;
  localparam int IW    = ADC_W + 3 + GUARD;
  localparam logic [ANGLE_W-1:0] HALF_TURN = ANGLE_W'(1) << (ANGLE_W - 1);

  logic signed [IW-1:0] xR, yR;
  logic [ANGLE_W-1:0]   zR;
  logic [ANGLE_W-1:0]   atanTab [ITER];
  logic [ANGLE_W-1:0]   atanNow;
  logic signed [IW-1:0] xExt, yExt, xShr, yShr;

  // rounded micro-rotation angles for the chosen angle width
  generate
    for (genvar i = 0; i < ITER; i++) begin : g_atan
      localparam logic [32:0] RAW = {1'b0, atanTurn32(i)};
      localparam logic [32:0] RND = (RAW + (33'd1 << (31 - ANGLE_W))) >> (32 - ANGLE_W);
      assign atanTab[i] = RND[ANGLE_W-1:0];
    end
  endgenerate

  always_comb begin
    atanNow = '0;
    for (int i = 0; i < ITER; i++)
      if (stepIdx == SEQ_W'(i)) atanNow = atanTab[i];
  end

  assign xExt = IW'(xIn) <<< GUARD;
  assign yExt = IW'(yIn) <<< GUARD;
  assign xShr = xR >>> stepIdx;
  assign yShr = yR >>> stepIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xR <= '0;
      yR <= '0;
      zR <= '0;
    end else if (load) begin
      if (xExt < 0) begin
        xR <= -xExt;
        yR <= -yExt;
        zR <= HALF_TURN;
      end else begin
        xR <= xExt;
        yR <= yExt;
        zR <= '0;
      end
    end else if (step) begin
      if (yR >= 0) begin
        xR <= xR + yShr;
        yR <= yR - xShr;
        zR <= zR + atanNow;
      end else begin
        xR <= xR - yShr;
        yR <= yR + xShr;
        zR <= zR - atanNow;
      end
    end
  end

  assign angle = zR;

  // R5
  xpos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (load || step) |=> !xR[IW-1]);

endmodule

// File: rtl/dptr_datapath.sv
`timescale 1ns/1ps
module dptr_datapath
  import dptr_pkg::*;
#(
  parameter int ADC_W   = 12,
  parameter int ANGLE_W = 16,
  parameter int ITER    = 16,
  parameter int NBINS   = 650,
  parameter int CNT_W   = 9,
  parameter int SEQ_W   = 5,
  parameter int BIN_W   = 10,
  parameter int RES_W   = 21
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            stb,
  input  logic [SEQ_W-1:0]        seqCnt,
  input  logic [ADC_W-1:0]        startX,
  input  logic [ADC_W-1:0]        startY,
  input  logic [ADC_W-1:0]        stopX,
  input  logic [ADC_W-1:0]        stopY,
  input  logic [CNT_W-1:0]        coarseCnt,
  input  logic [ADC_W-1:0]        midCode,
  input  logic                    tabWrEn,
  input  logic [BIN_W-1:0]        tabAddr,
  input  logic [ANGLE_W-1:0]      tabData,
  output logic signed [RES_W-1:0] result
);

  localparam int EDGE_N = NBINS - 1;
  localparam int STEPS  = BIN_W;

  logic [ADC_W-1:0]   capX0, capY0, capX1, capY1, capMid;
  logic [CNT_W-1:0]   capCoarse;
  logic [ADC_W-1:0]   selX, selY;
  logic signed [ADC_W:0] cordX, cordY;
  logic [ANGLE_W-1:0] cordAngle, angleR;
  logic [ANGLE_W-1:0] edgeTab [EDGE_N];
  logic [BIN_W-1:0]   candR, bin0R, bin1R, trial, tabIdx;
  logic               inRange, take;
  int                 bitPos;

  // capture of the accepted pair set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capX0 <= '0; capY0 <= '0; capX1 <= '0; capY1 <= '0;
      capMid <= '0; capCoarse <= '0;
    end else if (stb.capture) begin
      capX0 <= startX; capY0 <= startY;
      capX1 <= stopX;  capY1 <= stopY;
      capMid <= midCode; capCoarse <= coarseCnt;
    end
  end

  // offset removal into signed amplitudes
  assign selX  = stb.pairSel ? capX1 : capX0;
  assign selY  = stb.pairSel ? capY1 : capY0;
  assign cordX = $signed({1'b0, selX}) - $signed({1'b0, capMid});
  assign cordY = $signed({1'b0, selY}) - $signed({1'b0, capMid});

  dptr_cordic #(
    .ADC_W(ADC_W), .ANGLE_W(ANGLE_W), .ITER(ITER), .SEQ_W(SEQ_W)
  ) cordic_i (
    .clk(clk), .rstN(rstN),
    .load(stb.cordLoad), .step(stb.cordStep), .stepIdx(seqCnt),
    .xIn(cordX), .yIn(cordY), .angle(cordAngle)
  );

  // edge table storage
  always_ff @(posedge clk) begin
    if (tabWrEn && (tabAddr < BIN_W'(EDGE_N)))
      edgeTab[tabAddr] <= tabData;
  end

  // one candidate bit per step, most significant first
  always_comb begin
    bitPos  = (STEPS - 1) - int'(seqCnt);
    trial   = candR | (BIN_W'(1) << bitPos);
    inRange = (trial != '0) && (trial <= BIN_W'(EDGE_N));
    tabIdx  = inRange ? (trial - BIN_W'(1)) : '0;
    take    = inRange && (edgeTab[tabIdx] <= angleR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      angleR <= '0;
      candR  <= '0;
      bin0R  <= '0;
      bin1R  <= '0;
      result <= '0;
    end else begin
      if (stb.srchLoad) begin
        angleR <= cordAngle;
        candR  <= '0;
      end else if (stb.srchStep && take) begin
        candR <= trial;
      end
      if (stb.saveBin) begin
        if (stb.pairSel) bin1R <= candR;
        else             bin0R <= candR;
      end
      if (stb.calcOut)
        result <= RES_W'(capCoarse) * RES_W'(NBINS) + RES_W'(bin1R) - RES_W'(bin0R);
    end
  end

  // R6
  bin_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.saveBin |-> (candR <= BIN_W'(EDGE_N)));

endmodule

// File: rtl/dptr_ctrl.sv
`timescale 1ns/1ps
module dptr_ctrl
  import dptr_pkg::*;
#(
  parameter int ITER  = 16,
  parameter int STEPS = 10,
  parameter int SEQ_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output ctrlStrobes_t     stb,
  output logic [SEQ_W-1:0] seqCnt
);

  typedef enum logic [2:0] {
    S_IDLE, S_CLOAD, S_CITER, S_SLOAD, S_SSTEP, S_SAVE, S_CALC, S_HOLD
  } seqState_t;

  seqState_t state;
  logic      pairR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      seqCnt <= '0;
      pairR  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (inValid) begin
          state <= S_CLOAD;
          pairR <= 1'b0;
        end
        S_CLOAD: begin
          state  <= S_CITER;
          seqCnt <= '0;
        end
        S_CITER: begin
          if (seqCnt == SEQ_W'(ITER - 1)) state <= S_SLOAD;
          else seqCnt <= seqCnt + 1'b1;
        end
        S_SLOAD: begin
          state  <= S_SSTEP;
          seqCnt <= '0;
        end
        S_SSTEP: begin
          if (seqCnt == SEQ_W'(STEPS - 1)) state <= S_SAVE;
          else seqCnt <= seqCnt + 1'b1;
        end
        S_SAVE: begin
          if (pairR) state <= S_CALC;
          else begin
            pairR <= 1'b1;
            state <= S_CLOAD;
          end
        end
        S_CALC: state <= S_HOLD;
        S_HOLD: if (outReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.pairSel  = pairR;
    stb.capture  = (state == S_IDLE) && inValid;
    stb.cordLoad = (state == S_CLOAD);
    stb.cordStep = (state == S_CITER);
    stb.srchLoad = (state == S_SLOAD);
    stb.srchStep = (state == S_SSTEP);
    stb.saveBin  = (state == S_SAVE);
    stb.calcOut  = (state == S_CALC);
  end

  assign inReady  = (state == S_IDLE);
  assign outValid = (state == S_HOLD);

endmodule

// File: rtl/dual_phase_interval.sv
`timescale 1ns/1ps
module dual_phase_interval
  import dptr_pkg::*;
#(
  parameter int ADC_W   = 12,
  parameter int ANGLE_W = 16,
  parameter int ITER    = 16,
  parameter int NBINS   = 650,
  parameter int CNT_W   = 9
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       inValid,
  output logic                                       inReady,
  input  logic [ADC_W-1:0]                           startX,
  input  logic [ADC_W-1:0]                           startY,
  input  logic [ADC_W-1:0]                           stopX,
  input  logic [ADC_W-1:0]                           stopY,
  input  logic [CNT_W-1:0]                           coarseCnt,
  input  logic [ADC_W-1:0]                           midCode,
  input  logic                                       tabWrEn,
  input  logic [$clog2(NBINS)-1:0]                   tabAddr,
  input  logic [ANGLE_W-1:0]                         tabData,
  output logic                                       outValid,
  input  logic                                       outReady,
  output logic signed [CNT_W+$clog2(NBINS)+1:0]      intervalLsb
);

  localparam int BIN_W  = $clog2(NBINS);
  localparam int RES_W  = CNT_W + BIN_W + 2;
  localparam int MAXSEQ = (ITER > BIN_W) ? ITER : BIN_W;
  localparam int SEQ_W  = $clog2(MAXSEQ + 1);

  ctrlStrobes_t     stb;
  logic [SEQ_W-1:0] seqCnt;

  dptr_ctrl #(
    .ITER(ITER), .STEPS(BIN_W), .SEQ_W(SEQ_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid),
    .stb(stb), .seqCnt(seqCnt)
  );

  dptr_datapath #(
    .ADC_W(ADC_W), .ANGLE_W(ANGLE_W), .ITER(ITER), .NBINS(NBINS),
    .CNT_W(CNT_W), .SEQ_W(SEQ_W), .BIN_W(BIN_W), .RES_W(RES_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .seqCnt(seqCnt),
    .startX(startX), .startY(startY), .stopX(stopX), .stopY(stopY),
    .coarseCnt(coarseCnt), .midCode(midCode),
    .tabWrEn(tabWrEn), .tabAddr(tabAddr), .tabData(tabData),
    .result(intervalLsb)
  );

  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(intervalLsb)));

endmodule

// File: tb/dual_phase_interval_tb_top.sv
`timescale 1ns/1ps
module dual_phase_interval_tb_top;

  localparam int ADC_W   = 12;
  localparam int ANGLE_W = 16;
  localparam int ITER    = 16;
  localparam int NB      = 8;
  localparam int CNT_W   = 9;
  localparam int BIN_W   = $clog2(NB);
  localparam int RES_W   = CNT_W + BIN_W + 2;
  localparam int PAIR_CYC = ITER + BIN_W + 3;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b0, tabWrEn = 1'b0;
  logic inReady, outValid;
  logic [ADC_W-1:0] startX = '0, startY = '0, stopX = '0, stopY = '0, midCode = '0;
  logic [CNT_W-1:0] coarseCnt = '0;
  logic [BIN_W-1:0] tabAddr = '0;
  logic [ANGLE_W-1:0] tabData = '0;
  logic signed [RES_W-1:0] intervalLsb;

  always #2 clk = ~clk;

  dual_phase_interval #(
    .ADC_W(ADC_W), .ANGLE_W(ANGLE_W), .ITER(ITER), .NBINS(NB), .CNT_W(CNT_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .startX(startX), .startY(startY), .stopX(stopX), .stopY(stopY),
    .coarseCnt(coarseCnt), .midCode(midCode),
    .tabWrEn(tabWrEn), .tabAddr(tabAddr), .tabData(tabData),
    .outValid(outValid), .outReady(outReady), .intervalLsb(intervalLsb)
  );

  int compared = 0, mismatched = 0;
  bit started = 0, finished = 0;
  string curReq = "R1";
  int benchEdge [NB-1];

  // behavioural reference: 0 idle, 1 busy, 2 holding a result
  int mState = 0, mCnt = 0, mExp = 0;

  function automatic int angleCode(int dx, int dy);
    real th;
    th = $atan2(real'(dy), real'(dx));
    if (th < 0.0) th = th + TWO_PI;
    return int'($floor(th / TWO_PI * 65536.0)) % 65536;
  endfunction

  function automatic int binOf(int code);
    int n = 0;
    for (int k = 0; k < NB - 1; k++) if (benchEdge[k] <= code) n++;
    return n;
  endfunction

  function automatic int expectedNow();
    int m = int'(midCode);
    int b0 = binOf(angleCode(int'(startX) - m, int'(startY) - m));
    int b1 = binOf(angleCode(int'(stopX) - m, int'(stopY) - m));
    return int'(coarseCnt) * NB + b1 - b0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0;
      mCnt = 0;
    end else begin
      case (mState)
        0: if (inValid) begin
          mExp = expectedNow();
          mCnt = 2 * PAIR_CYC;
          mState = 1;
        end
        1: if (mCnt == 0) mState = 2; else mCnt--;
        default: if (outReady) mState = 0;
      endcase
    end
  end

  task automatic check(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", curReq, what, act, exp);
    end
  endtask

  // comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && rstN) begin
      check("inReady", int'(inReady), (mState == 0) ? 1 : 0);
      check("outValid", int'(outValid), (mState == 2) ? 1 : 0);
      if (mState == 2) check("intervalLsb", int'(intervalLsb), mExp);
    end
  end

  task automatic writeEdge(input int addr, input int code);
    @(negedge clk);
    tabWrEn = 1'b1;
    tabAddr = BIN_W'(addr);
    tabData = ANGLE_W'(code);
    benchEdge[addr] = code;
    @(negedge clk);
    tabWrEn = 1'b0;
  endtask

  task automatic runPair(input int dx0, input int dy0, input int dx1, input int dy1,
                         input int coarse, input int mid, input int stall, input bit scramble);
    @(negedge clk);
    midCode   = ADC_W'(mid);
    startX    = ADC_W'(mid + dx0);
    startY    = ADC_W'(mid + dy0);
    stopX     = ADC_W'(mid + dx1);
    stopY     = ADC_W'(mid + dy1);
    coarseCnt = CNT_W'(coarse);
    inValid   = 1'b1;
    @(negedge clk);
    if (scramble) begin
      startX = ~startX; stopY = ~stopY; midCode = midCode + 12'd77;
      coarseCnt = ~coarseCnt;
      repeat (10) @(negedge clk);
    end
    inValid = 1'b0;
    while (mState != 2) @(negedge clk);
    repeat (stall) @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    check("reset inReady", int'(inReady), 1);
    check("reset outValid", int'(outValid), 0);
    started = 1;

    // R6: ascending nonuniform edges
    curReq = "R6";
    writeEdge(0, 5000);  writeEdge(1, 12000); writeEdge(2, 20000);
    writeEdge(3, 30000); writeEdge(4, 43000); writeEdge(5, 50000);
    writeEdge(6, 58000);

    curReq = "R5";  runPair(1500, 60, 0, 1500, 0, 2048, 0, 0);         // 2
    curReq = "R5";  runPair(0, 1500, -1500, 0, 3, 2048, 0, 0);         // 26
    curReq = "R7";  runPair(0, -1500, 1000, 1000, 0, 2048, 0, 0);      // -4
    curReq = "R5";  runPair(200, 200, 1400, 1400, 1, 2048, 0, 0);      // 8, magnitude ignored
    curReq = "R10"; runPair(1500, -50, 1500, 60, 2, 2048, 0, 0);       // 9
    curReq = "R9";  runPair(-1000, 1000, 1000, -1000, 511, 2048, 0, 0);// 4091
    curReq = "R4";  runPair(-1000, -1000, 1200, -300, 5, 1000, 0, 0);  // 43
    curReq = "R2";  runPair(1000, -1000, -1000, 1000, 4, 2048, 0, 1);  // 29, busy inputs ignored
    curReq = "R3";  runPair(-1500, 0, 0, 1500, 1, 2048, 7, 0);         // 6, held under back-pressure

    // R8: moved edge applies to the next pair; out-of-range address ignored
    curReq = "R8";
    writeEdge(0, 9000);
    @(negedge clk); tabWrEn = 1'b1; tabAddr = BIN_W'(7); tabData = 16'd1;
    @(negedge clk); tabWrEn = 1'b0;
    runPair(1000, 1000, -1000, 1000, 0, 2048, 0, 0);                   // 3
    runPair(1500, 60, 1200, -300, 0, 2048, 0, 0);                      // 7

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R3 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule